// File: doc/BRIEF.md
# I2C-over-AUX Transaction Engine

This block carries out one I2C phase over a byte-oriented auxiliary channel. The host picks a phase (address-only start, write one byte, read one byte, or address-only stop), a direction for the address-only phases, a 16-bit target address and, for writes, a data byte. It then pulses `go`. The engine builds a short request packet and streams it to a lower-layer channel as a valid/ready byte stream, marking the final byte. It then decodes the reply that comes back on a byte stream.

A reply that asks the requester to defer makes the engine wait for a fixed time and send the identical request again. An optional limit on the number of defers turns a sink that stalls forever into a timeout. The outcome is one of: success (with read data for a read), refusal, malformed reply, lower-layer failure or timeout. It is reported with a one-cycle `done` pulse.

The controller states are IDLE, SEND, RECV, WAIT and FIN:
- IDLE goes to SEND on `go`.
- SEND goes to RECV when the marked final byte is accepted, or to FIN on `chan_err`.
- RECV goes to FIN on a final reply, to WAIT on a defer, to FIN on a defer that reaches the limit, and to FIN on `chan_err`. It stays in RECV while a read's data byte is still due.
- WAIT goes back to SEND when the defer timer expires.
- FIN always returns to IDLE.

Top module: `aux_i2c_xact`

## Requirements
- R1: The first request byte is the command. Bit 4 is 1 for a read and 0 for a write: a read phase always reads, a write phase always writes, and start/stop take `rd_dir`. Bit 6 (keep-open) is 1 for every phase except stop. All other bits are 0.
- R2: Request bytes at index 1 and 2 are `tgt_addr[15:8]` and then `tgt_addr[7:0]`.
- R3: The request length depends on the phase, encoded in `mode` as 0=start, 1=write, 2=read, 3=stop. A write sends 5 bytes, with index 3 = 0x00 and index 4 = `wr_byte`. A read sends 4 bytes, with index 3 = 0x00. Start and stop send 3 bytes. `tx_last` is high exactly on the final byte.
- R4: The reply code is bits 7:6 of the first reply byte, and bits 5:0 are ignored. Code 00 (ACK) ends with status 0. For a read, the engine first takes a second reply byte into `rd_data` and sets `result_len`=1. For other phases `result_len` is 0.
- R5: Code 01 ends with status 1 (refused). Code 11 ends with status 2 (malformed). In both cases `result_len` is 0 and `rd_data` is 0.
- R6: Code 10 (defer) makes `tx_valid` stay low for exactly DEFER_US microseconds of clock cycles. After that the identical request is sent again.
- R7: `chan_err` during SEND or RECV ends the transaction with status 3 on the next cycle.
- R8: When MAX_DEFER is nonzero, the MAX_DEFER-th defer ends the transaction with status 4 and no resend.
- R9: `go` in IDLE makes `busy` high on the next cycle. `done` is a one-cycle pulse, and `busy` is low on the cycle after it. `go` while busy is ignored.
- R10: After reset, `busy`, `done` and `tx_valid` are low.
- R11: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| go | input | 1 | Start a transaction (taken in IDLE only) |
| mode | input | 2 | Phase: 0 start, 1 write, 2 read, 3 stop |
| rd_dir | input | 1 | Direction for start/stop phases |
| tgt_addr | input | 16 | Target address |
| wr_byte | input | 8 | Data byte for a write phase |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 3 | 0 ok, 1 refused, 2 malformed, 3 link error, 4 timeout |
| rd_data | output | 8 | Byte returned by a read |
| result_len | output | 1 | 1 when `rd_data` holds a returned byte |
| tx_valid | output | 1 | Request byte valid |
| tx_data | output | 8 | Request byte |
| tx_last | output | 1 | Final request byte |
| tx_ready | input | 1 | Channel accepts the request byte |
| rx_valid | input | 1 | Reply byte valid |
| rx_data | input | 8 | Reply byte |
| chan_err | input | 1 | Lower-layer channel failure |

## Verification
The bench targets the reply byte whose low six bits are nonzero. A decoder that compared the whole byte would report malformed instead of ACK or refused. It measures the gap after a defer to the cycle, which catches a timer that is off by one, and it compares the resent bytes, which catches a resend that lost the latched request. It drives the defer limit exactly: an engine that counts wrongly would either send a fourth request or time out early. Further tests stall the channel and pulse `go` mid-request, and raise `chan_err` mid-request. A design that let the new `go` overwrite the request, or ignored the failure, shows wrong bytes or no `done`.

// File: rtl/aux_i2c_pkg.sv
package aux_i2c_pkg;

    typedef enum logic [1:0] {
        PH_START = 2'd0,
        PH_WRITE = 2'd1,
        PH_READ  = 2'd2,
        PH_STOP  = 2'd3
    } phase_t;

    typedef enum logic [2:0] {
        ACT_OK    = 3'd0,
        ACT_NACK  = 3'd1,
        ACT_BAD   = 3'd2,
        ACT_DEFER = 3'd3,
        ACT_MORE  = 3'd4
    } act_t;

    typedef enum logic [2:0] {
        XS_OK   = 3'd0,
        XS_NACK = 3'd1,
        XS_BAD  = 3'd2,
        XS_LINK = 3'd3,
        XS_TMO  = 3'd4
    } xstat_t;

    typedef struct packed {
        phase_t      phase;
        logic        rd;
        logic [15:0] addr;
        logic [7:0]  wdata;
    } req_t;

    localparam int IDX_W = 3;

endpackage

// File: rtl/aux_i2c_req_fmt.sv
module aux_i2c_req_fmt
    import aux_i2c_pkg::*;
(
    input  req_t             req,
    input  logic [IDX_W-1:0] idx,
    output logic [7:0]       byte_o,
    output logic [IDX_W-1:0] req_len,
    output logic             rsp_two
);
    logic       is_rd;
    logic       keep_open;
    logic [7:0] cmd;

    always_comb begin
        unique case (req.phase)
            PH_WRITE: is_rd = 1'b0;
            PH_READ:  is_rd = 1'b1;
            default:  is_rd = req.rd;
        endcase
        keep_open = (req.phase != PH_STOP);
        cmd       = {1'b0, keep_open, 1'b0, is_rd, 4'b0000};
    end

    always_comb begin
        unique case (req.phase)
            PH_WRITE: req_len = IDX_W'(5);
            PH_READ:  req_len = IDX_W'(4);
            default:  req_len = IDX_W'(3);
        endcase
        rsp_two = (req.phase == PH_READ);
    end

    always_comb begin
        unique case (idx)
            IDX_W'(0): byte_o = cmd;
            IDX_W'(1): byte_o = req.addr[15:8];
            IDX_W'(2): byte_o = req.addr[7:0];
            IDX_W'(3): byte_o = 8'h00;
            IDX_W'(4): byte_o = req.wdata;
            default:   byte_o = 8'h00;
        endcase
    end
endmodule

// File: rtl/aux_i2c_rsp_dec.sv
module aux_i2c_rsp_dec
    import aux_i2c_pkg::*;
(
    input  logic [1:0] code,
    input  logic       want_data,
    output act_t       act
);
    always_comb begin
        unique case (code)
            2'b00:   act = want_data ? ACT_MORE : ACT_OK;
            2'b01:   act = ACT_NACK;
            2'b10:   act = ACT_DEFER;
            default: act = ACT_BAD;
        endcase
    end
endmodule

// File: rtl/aux_i2c_wait_timer.sv
module aux_i2c_wait_timer #(
    parameter int CYCLES = 10000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int TW = (CYCLES > 1) ? $clog2(CYCLES + 1) : 1;

    logic [TW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cnt <= '0;
        else if (!run)  cnt <= '0;
        else            cnt <= cnt + TW'(1);
    end

    assign expired = run && (cnt == TW'(CYCLES - 1));

    // R6: every wait starts from a cleared count
    assert_wait_fresh_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> (cnt == '0));
endmodule

// File: rtl/aux_i2c_xact.sv
module aux_i2c_xact
    import aux_i2c_pkg::*;
#(
    parameter int CLK_HZ    = 100_000_000,
    parameter int DEFER_US  = 100,
    parameter int MAX_DEFER = 0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        go,
    input  logic [1:0]  mode,
    input  logic        rd_dir,
    input  logic [15:0] tgt_addr,
    input  logic [7:0]  wr_byte,
    output logic        busy,
    output logic        done,
    output logic [2:0]  status,
    output logic [7:0]  rd_data,
    output logic        result_len,
    output logic        tx_valid,
    output logic [7:0]  tx_data,
    output logic        tx_last,
    input  logic        tx_ready,
    input  logic        rx_valid,
    input  logic [7:0]  rx_data,
    input  logic        chan_err
);
    localparam int WAIT_CYC = (CLK_HZ / 1_000_000) * DEFER_US;
    localparam int DCW      = $clog2(MAX_DEFER + 2);

    typedef enum logic [2:0] {S_IDLE, S_SEND, S_RECV, S_WAIT, S_FIN} state_t;

    state_t           state, nxt;
    req_t             req_q;
    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] req_len;
    logic             rsp_two;
    logic             got_code;
    logic [DCW-1:0]   defer_cnt;
    xstat_t           stat_q;
    logic [7:0]       rdata_q;
    logic             rlen_q;
    logic             tmr_run;
    logic             tmr_exp;
    logic             last_idx;
    logic             hit_limit;
    act_t             act;

    aux_i2c_req_fmt u_fmt (
        .req     (req_q),
        .idx     (idx),
        .byte_o  (tx_data),
        .req_len (req_len),
        .rsp_two (rsp_two)
    );

    aux_i2c_rsp_dec u_dec (
        .code      (rx_data[7:6]),
        .want_data (rsp_two),
        .act       (act)
    );

    aux_i2c_wait_timer #(.CYCLES(WAIT_CYC)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (tmr_run),
        .expired (tmr_exp)
    );

    assign last_idx  = (idx == req_len - IDX_W'(1));
    assign hit_limit = (MAX_DEFER != 0) && (defer_cnt == DCW'(MAX_DEFER - 1));

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: if (go) nxt = S_SEND;
            S_SEND: begin
                if (chan_err)                  nxt = S_FIN;
                else if (tx_ready && last_idx) nxt = S_RECV;
            end
            S_RECV: begin
                if (chan_err) nxt = S_FIN;
                else if (rx_valid) begin
                    if (got_code)              nxt = S_FIN;
                    else if (act == ACT_MORE)  nxt = S_RECV;
                    else if (act == ACT_DEFER) nxt = hit_limit ? S_FIN : S_WAIT;
                    else                       nxt = S_FIN;
                end
            end
            S_WAIT: if (tmr_exp) nxt = S_SEND;
            S_FIN:  nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q     <= '0;
            idx       <= '0;
            got_code  <= 1'b0;
            defer_cnt <= '0;
            stat_q    <= XS_OK;
            rdata_q   <= '0;
            rlen_q    <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: if (go) begin
                    req_q     <= '{phase: phase_t'(mode), rd: rd_dir,
                                   addr: tgt_addr, wdata: wr_byte};
                    idx       <= '0;
                    got_code  <= 1'b0;
                    defer_cnt <= '0;
                    stat_q    <= XS_OK;
                    rdata_q   <= '0;
                    rlen_q    <= 1'b0;
                end
                S_SEND: begin
                    if (chan_err)      stat_q <= XS_LINK;
                    else if (tx_ready) idx    <= last_idx ? '0 : idx + IDX_W'(1);
                end
                S_RECV: begin
                    if (chan_err) stat_q <= XS_LINK;
                    else if (rx_valid) begin
                        if (got_code) begin
                            rdata_q <= rx_data;
                            rlen_q  <= 1'b1;
                            stat_q  <= XS_OK;
                        end else begin
                            unique case (act)
                                ACT_OK:   stat_q   <= XS_OK;
                                ACT_MORE: got_code <= 1'b1;
                                ACT_NACK: stat_q   <= XS_NACK;
                                ACT_BAD:  stat_q   <= XS_BAD;
                                ACT_DEFER: begin
                                    defer_cnt <= defer_cnt + DCW'(1);
                                    if (hit_limit) stat_q <= XS_TMO;
                                end
                                default:  stat_q   <= XS_BAD;
                            endcase
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs decoded from state
    always_comb begin
        busy       = (state != S_IDLE);
        done       = (state == S_FIN);
        tx_valid   = (state == S_SEND);
        tx_last    = (state == S_SEND) && last_idx;
        tmr_run    = (state == S_WAIT);
        status     = stat_q;
        rd_data    = rdata_q;
        result_len = rlen_q;
    end

    // R11: a stalled request byte is held
    assert_tx_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready && !chan_err |=> tx_valid && $stable(tx_data) && $stable(tx_last));

    // R3: nothing follows the marked final byte
    assert_req_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && tx_ready && tx_last && !chan_err |=> !tx_valid);

    // R9: done lasts one cycle and busy falls after it
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !busy);

    // R4: a successful read reports its data byte, other phases do not
    assert_ack_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done && (status == XS_OK) |-> (result_len == (req_q.phase == PH_READ)));

    // R8: timeout only after exactly the configured number of defers
    assert_timeout_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done && (status == XS_TMO) |-> (MAX_DEFER != 0) && (defer_cnt == DCW'(MAX_DEFER)));

    // R7: a lower-layer failure in flight finishes on the next cycle
    assert_link_R7: assert property (@(posedge clk) disable iff (!rst_n)
        chan_err && (tx_valid || (busy && !done && !tmr_run)) |=> done && (status == XS_LINK));
endmodule

// File: tb/sim_aux_i2c_xact.sv
module sim_aux_i2c_xact;
    localparam int WAIT_N = 100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        go = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic        rd_dir = 1'b0;
    logic [15:0] tgt_addr = 16'h0;
    logic [7:0]  wr_byte = 8'h0;
    logic        busy, done, result_len, tx_valid, tx_last;
    logic [2:0]  status;
    logic [7:0]  rd_data, tx_data;
    logic        tx_ready = 1'b1;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = 8'h0;
    logic        chan_err = 1'b0;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    aux_i2c_xact #(.CLK_HZ(100_000_000), .DEFER_US(1), .MAX_DEFER(3)) u0 (
        .clk(clk), .rst_n(rst_n), .go(go), .mode(mode), .rd_dir(rd_dir),
        .tgt_addr(tgt_addr), .wr_byte(wr_byte), .busy(busy), .done(done),
        .status(status), .rd_data(rd_data), .result_len(result_len),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
        .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_data(rx_data),
        .chan_err(chan_err)
    );

    typedef struct packed {
        logic [1:0]  m;
        logic        rd;
        logic [15:0] a;
        logic [7:0]  w;
        logic [7:0]  r0;
        logic [7:0]  r1;
        logic [2:0]  st;
        logic [7:0]  rdv;
        logic        len;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{2'd0, 1'b0, 16'h0050, 8'h00, 8'h00, 8'h00, 3'd0, 8'h00, 1'b0},
        '{2'd1, 1'b0, 16'h0050, 8'hA5, 8'h00, 8'h00, 3'd0, 8'h00, 1'b0},
        '{2'd2, 1'b0, 16'h1237, 8'h00, 8'h00, 8'h3C, 3'd0, 8'h3C, 1'b1},
        '{2'd3, 1'b1, 16'h0050, 8'h00, 8'h00, 8'h00, 3'd0, 8'h00, 1'b0},
        '{2'd1, 1'b1, 16'hBEEF, 8'h5A, 8'h5F, 8'h00, 3'd1, 8'h00, 1'b0},
        '{2'd2, 1'b0, 16'h00A0, 8'h00, 8'hC0, 8'h77, 3'd2, 8'h00, 1'b0},
        '{2'd0, 1'b1, 16'hFFFF, 8'h00, 8'h3F, 8'h00, 3'd0, 8'h00, 1'b0},
        '{2'd3, 1'b0, 16'h8001, 8'h00, 8'h00, 8'h00, 3'd0, 8'h00, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int exp_len(input logic [1:0] m);
        return (m == 2'd1) ? 5 : (m == 2'd2) ? 4 : 3;
    endfunction

    function automatic logic [7:0] exp_byte(input logic [1:0] m, input logic rd,
                                            input logic [15:0] a, input logic [7:0] w, input int i);
        logic rdb;
        rdb = (m == 2'd2) ? 1'b1 : (m == 2'd1) ? 1'b0 : rd;
        case (i)
            0: return ((m != 2'd3) ? 8'h40 : 8'h00) | (rdb ? 8'h10 : 8'h00);
            1: return a[15:8];
            2: return a[7:0];
            3: return 8'h00;
            default: return w;
        endcase
    endfunction

    task automatic start(input logic [1:0] m, input logic rd, input logic [15:0] a, input logic [7:0] w);
        mode = m; rd_dir = rd; tgt_addr = a; wr_byte = w; go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        chk("R9 busy after go", busy, 1);
    endtask

    task automatic collect(input logic [1:0] m, input logic rd, input logic [15:0] a,
                           input logic [7:0] w, input bit stall);
        for (int i = 0; i < exp_len(m); i++) begin
            while (!tx_valid) @(negedge clk);
            chk((i == 0) ? "R1 command byte" : (i < 3) ? "R2 address byte" : "R3 tail byte",
                tx_data, exp_byte(m, rd, a, w, i));
            chk("R3 last marker", tx_last, (i == exp_len(m) - 1) ? 1 : 0);
            if (stall && i == 1) begin
                tx_ready = 1'b0;
                mode = 2'd3; tgt_addr = 16'h1111; go = 1'b1;
                for (int k = 0; k < 3; k++) begin
                    @(negedge clk);
                    go = 1'b0;
                    chk("R11 held valid", tx_valid, 1);
                    chk("R11 held data", tx_data, exp_byte(m, rd, a, w, i));
                end
                tx_ready = 1'b1;
            end
            @(negedge clk);
        end
    endtask

    task automatic reply(input logic [7:0] r0, input logic [7:0] r1, input bit two);
        rx_valid = 1'b1; rx_data = r0;
        @(negedge clk);
        if (two) begin
            rx_data = r1;
            @(negedge clk);
        end
        rx_valid = 1'b0;
    endtask

    task automatic finish_chk(input string tag, input logic [2:0] st, input logic [7:0] rdv, input logic len);
        chk({tag, " done"}, done, 1);
        chk({tag, " status"}, status, st);
        chk({tag, " rd_data"}, rd_data, rdv);
        chk({tag, " result_len"}, result_len, len);
        @(negedge clk);
        chk("R9 done pulse ends", done, 0);
        chk("R9 idle after done", busy, 0);
    endtask

    task automatic defer_gap();
        int gap = 0;
        while (!tx_valid && gap < 1000) begin
            gap++;
            @(negedge clk);
        end
        chk("R6 defer wait cycles", gap, WAIT_N);
    endtask

    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                fails++; checks++;
                $display("FAIL watchdog actual=hung expected=finished");
                $display("Result: errors=%0d of %0d checks", fails, checks);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R10 busy at reset", busy, 0);
        chk("R10 done at reset", done, 0);
        chk("R10 tx_valid at reset", tx_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // vector table: R1 R2 R3 R4 R5
        foreach (VEC[n]) begin
            vec_t v = VEC[n];
            bit two = (v.m == 2'd2) && (v.r0[7:6] == 2'b00);
            start(v.m, v.rd, v.a, v.w);
            collect(v.m, v.rd, v.a, v.w, 1'b0);
            reply(v.r0, v.r1, two);
            finish_chk((v.st == 3'd0) ? "R4" : "R5", v.st, v.rdv, v.len);
        end

        // R11 stall with go pulse while busy (R9 ignore)
        start(2'd2, 1'b0, 16'h4321, 8'h00);
        collect(2'd2, 1'b0, 16'h4321, 8'h00, 1'b1);
        reply(8'h00, 8'h99, 1'b1);
        finish_chk("R9 ignored go", 3'd0, 8'h99, 1'b1);

        // R6 defer then identical resend
        start(2'd1, 1'b0, 16'h0A0B, 8'hC3);
        collect(2'd1, 1'b0, 16'h0A0B, 8'hC3, 1'b0);
        reply(8'h80, 8'h00, 1'b0);
        defer_gap();
        collect(2'd1, 1'b0, 16'h0A0B, 8'hC3, 1'b0);
        reply(8'h00, 8'h00, 1'b0);
        finish_chk("R6", 3'd0, 8'h00, 1'b0);

        // R8 third defer times out
        start(2'd2, 1'b0, 16'h0055, 8'h00);
        for (int d = 0; d < 3; d++) begin
            collect(2'd2, 1'b0, 16'h0055, 8'h00, 1'b0);
            reply(8'h80, 8'h00, 1'b0);
            if (d < 2) defer_gap();
        end
        chk("R8 no resend after limit", tx_valid, 0);
        finish_chk("R8", 3'd4, 8'h00, 1'b0);

        // R7 channel failure mid-request
        start(2'd1, 1'b0, 16'h2222, 8'h11);
        @(negedge clk);
        chan_err = 1'b1;
        @(negedge clk);
        chan_err = 1'b0;
        finish_chk("R7", 3'd3, 8'h00, 1'b0);

        // R7 channel failure while awaiting reply
        start(2'd0, 1'b0, 16'h3333, 8'h00);
        collect(2'd0, 1'b0, 16'h3333, 8'h00, 1'b0);
        chan_err = 1'b1;
        @(negedge clk);
        chan_err = 1'b0;
        finish_chk("R7 reply wait", 3'd3, 8'h00, 1'b0);

        $display("Result: errors=%0d of %0d checks", fails, checks);
        $finish;
    end
endmodule